// File: doc/BRIEF.md
# Port Input Change Interrupt Logic

This block watches a vector of general-purpose port pins and raises an interrupt request whenever a pin that is configured as an input no longer matches the level captured in the input-port snapshot. The request is carried on `irq_pull`, an open-drain enable: a 1 pulls the shared active-low interrupt line low, and a 0 releases it. The snapshot is the value the serial-bus engine returns when the input-port register is read. It captures every pin, whatever that pin's direction.

The request goes away in two ways. The pins can return to the captured levels. Or the bus engine can pulse `rd_commit` on the clock that matches the rising clock edge of the ACK/NACK bit of an input-port read. On that edge the snapshot takes the present pin levels and the request is dropped. A pin change that lands on that same edge is absorbed into the new snapshot and is never reported. Any change after that edge is reported again.

The control is a three-state machine:
- `ST_INIT` is entered on reset. On the first clock after reset it loads the snapshot from the pins and moves to `ST_QUIET`.
- `ST_QUIET` means no difference is pending. It goes to `ST_ALERT` when a masked difference exists and no commit is present. It stays in `ST_QUIET` on a commit.
- `ST_ALERT` drives the request. It goes back to `ST_QUIET` on a commit (read clear) or when no masked difference remains (revert clear). Otherwise it stays in `ST_ALERT`.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is asserted, `irq_pull` is 0. On the first clock edge after reset is released, `snap` takes `pin_sync` and `irq_pull` stays 0.
- R2: If a pin with `dir_in` bit = 1 (input) differs from its `snap` bit at a clock edge with no commit, `irq_pull` is 1 after that edge.
- R3: Both a 0-to-1 and a 1-to-0 change of an input pin raise the request.
- R4: When every input pin again equals its `snap` bit at a clock edge, `irq_pull` is 0 after that edge, with no read needed.
- R5: At a clock edge with `rd_commit` = 1, `snap` takes the value of `pin_sync` and `irq_pull` becomes 0.
- R6: A pin change that is present at the same edge as `rd_commit` is captured into `snap` and raises no request afterwards.
- R7: After a commit, a later difference on an input pin raises the request again.
- R8: Pins with `dir_in` bit = 0 (output) never raise the request, whatever their level.
- R9: Switching a pin from output (0) to input (1) while its level differs from `snap` raises the request one edge later.
- R10: `snap` changes only at a commit or at the first edge after reset. Bus activity that is not an input-port read commit leaves both `snap` and the request state unchanged.
- R11: A commit captures all pins into `snap`, including pins configured as outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_sync | input | PORT_W | Pin levels, already synchronized to `clk` |
| dir_in | input | PORT_W | Direction per pin: 1 = input, 0 = output |
| rd_commit | input | 1 | One-cycle strobe: input-port read reached its ACK/NACK edge |
| irq_pull | output | 1 | 1 = pull the active-low interrupt line low |
| snap | output | PORT_W | Input-port snapshot returned on reads |

## Verification
The assertions check four things on every cycle:
- a masked difference with no commit leads to a raised request on the next cycle;
- a commit or the absence of any difference drops the request;
- the snapshot holds between loads and captures the pins at a commit;
- an all-output direction never yields a request.

Some behaviours only the bench scenarios can show. These are the absorption of a change that coincides with a commit, the re-report of a change after a clear, the false interrupt when a direction bit is turned from output to input, and the capture of output pins into the snapshot. A long random run with sparse pin toggles, direction changes and commits compares every cycle against a bench model.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_QUIET = 2'd1,
        ST_ALERT = 2'd2
    } irq_state_t;

endpackage

// File: rtl/pcx_change_detect.sv
module pcx_change_detect #(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] snap,
    input  logic [PORT_W-1:0] dir_in,
    output logic [PORT_W-1:0] diff_vec,
    output logic              any_diff
);

    // One masked compare per pin: only input-direction pins count (R8)
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        assign diff_vec[i] = dir_in[i] & (pin_sync[i] ^ snap[i]);
    end

    assign any_diff = |diff_vec;

endmodule

// File: rtl/pcx_snapshot.sv
module pcx_snapshot #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] snap
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (load) begin
            snap <= pin_sync;
        end
    end

    // R10: snapshot only moves when a load is requested
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(snap))
        else $error("p_hold_r10");

endmodule

// File: rtl/pcx_irq_fsm.sv
module pcx_irq_fsm
    import pin_change_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_diff,
    input  logic       rd_commit,
    output logic       snap_load,
    output logic       irq_pull,
    output irq_state_t state_q
);

    irq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  state_d = ST_QUIET;
            ST_QUIET: begin
                if (!rd_commit && any_diff) state_d = ST_ALERT;
            end
            ST_ALERT: begin
                if (rd_commit || !any_diff) state_d = ST_QUIET;
            end
            default:  state_d = ST_INIT;
        endcase
    end

    always_comb begin
        snap_load = (state_q == ST_INIT) || rd_commit;
        irq_pull  = (state_q == ST_ALERT);
    end

    // R2: an unmasked difference without a commit raises the request
    p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_INIT && !rd_commit && any_diff) |=> irq_pull)
        else $error("p_raise_r2");

    // R5: a read commit drops the request
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_commit |=> !irq_pull)
        else $error("p_read_clear_r5");

    // R4: no pending difference drops the request
    p_revert_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_diff |=> !irq_pull)
        else $error("p_revert_clear_r4");

    // R1: the request is released while in reset
    always_comb begin
        if (!rst_n) begin
            a_reset_release_r1: assert (!irq_pull) else $error("a_reset_release_r1");
        end
    end

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pin_change_irq_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] dir_in,
    input  logic              rd_commit,
    output logic              irq_pull,
    output logic [PORT_W-1:0] snap
);

    logic [PORT_W-1:0] diff_vec;
    logic              any_diff;
    logic              snap_load;
    irq_state_t        state_q;

    pcx_change_detect #(.PORT_W(PORT_W)) u_detect (
        .pin_sync (pin_sync),
        .snap     (snap),
        .dir_in   (dir_in),
        .diff_vec (diff_vec),
        .any_diff (any_diff)
    );

    pcx_snapshot #(.PORT_W(PORT_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (snap_load),
        .pin_sync (pin_sync),
        .snap     (snap)
    );

    pcx_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_diff  (any_diff),
        .rd_commit (rd_commit),
        .snap_load (snap_load),
        .irq_pull  (irq_pull),
        .state_q   (state_q)
    );

    // R5 / R11: a commit captures every pin, whatever its direction
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_commit |=> (snap == $past(pin_sync)))
        else $error("p_capture_r5");

    // R8: with all pins as outputs no request can follow
    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in == '0) |=> !irq_pull)
        else $error("p_mask_r8");

endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_sync = 8'h5A;
    logic [W-1:0] dir_in = 8'hFF;
    logic         rd_commit = 1'b0;
    logic         irq_pull;
    logic [W-1:0] snap;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    // bench model
    logic [W-1:0] m_snap;
    logic         m_irq;
    bit           m_init;

    always #5 clk = ~clk;

    pin_change_irq #(.PORT_W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_sync  (pin_sync),
        .dir_in    (dir_in),
        .rd_commit (rd_commit),
        .irq_pull  (irq_pull),
        .snap      (snap)
    );

    // Expected request after an edge, from R2/R4/R5/R8
    function automatic logic exp_irq(logic [W-1:0] p, logic [W-1:0] d,
                                     logic [W-1:0] s, logic c);
        return !c && (((p ^ s) & d) != '0);
    endfunction

    task automatic check(string tag);
        n_vec++;
        if (irq_pull !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq_pull actual=%0b expected=%0b", tag, irq_pull, m_irq);
        end
        if (snap !== m_snap) begin
            n_fail++;
            $display("FAIL %s snap actual=%h expected=%h", tag, snap, m_snap);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, sample 1 ns later
    task automatic step(logic [W-1:0] p, logic [W-1:0] d, logic c, string tag);
        @(negedge clk);
        pin_sync  = p;
        dir_in    = d;
        rd_commit = c;
        @(posedge clk);
        if (m_init) begin
            m_snap = p;
            m_irq  = 1'b0;
            m_init = 0;
        end else begin
            m_irq = exp_irq(p, d, m_snap, c);
            if (c) m_snap = p;
        end
        #1;
        check(tag);
    endtask

    initial begin : watchdog
        while (cycles < 200000 && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] p;
        logic [W-1:0] d;
        void'($urandom(32'd1234));
        m_init = 1;
        m_snap = '0;
        m_irq  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (irq_pull !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 irq_pull in reset actual=%0b expected=0", irq_pull);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step(8'h5A, 8'hFF, 0, "R1 first edge loads pins");
        step(8'h5B, 8'hFF, 0, "R2 R3 rising input raises");
        step(8'h5A, 8'hFF, 0, "R4 revert clears");
        step(8'h58, 8'hFF, 0, "R3 falling input raises");
        step(8'h58, 8'hFF, 1, "R5 read commit clears");
        step(8'h58, 8'hFF, 0, "R5 stays clear after commit");
        step(8'h78, 8'hFF, 1, "R6 change with commit absorbed");
        step(8'h78, 8'hFF, 0, "R6 no late report");
        step(8'h79, 8'hFF, 0, "R7 change after clear reported");
        step(8'h79, 8'hFF, 1, "R7 clear again");
        step(8'h7F, 8'hF0, 0, "R8 output pins masked");
        step(8'h7F, 8'hF0, 0, "R10 snap holds without commit");
        step(8'h7F, 8'hFF, 0, "R9 output to input mismatch raises");
        step(8'h79, 8'hFF, 0, "R4 back to snapshot clears");
        step(8'hA5, 8'h00, 1, "R11 commit captures output pins");
        step(8'h5A, 8'h00, 0, "R8 all outputs never raise");
        step(8'h5A, 8'h00, 0, "R10 snap unchanged without commit");

        // Random phase: sparse toggles, occasional direction flips and commits
        p = 8'h5A;
        d = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 2) == 0) p = p ^ (8'h01 << $urandom_range(0, W-1));
            if ($urandom_range(0, 15) == 0) d = W'($urandom);
            step(p, d, ($urandom_range(0, 7) == 0), "R2 R4 R5 R10 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule